// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host-side master for a chain of up to four serial digital-to-analog converters. Each converter shares one serial clock line and one data line with the others, and each has its own active-low frame-select line. A single request carries a control byte, a data byte, a coded device address and a mode flag. The writer sends the two bytes as one 16-bit frame, with the control byte first and the most significant bit first. It brings the addressed select line low for the whole frame and pulses `done` once the line has been high again for long enough.

The serial clock idles low. Data changes only while the clock is low, and the receiver samples it on the rising clock edge. The width of each clock phase, the select setup and hold, the minimum select-high time between frames and the pause between bytes are all set by parameters counted in system-clock cycles. With `req_split` set, the frame goes out as two 8-bit bursts with a longer low pause between them. This matches a host that can only shift whole bytes. The select line stays low across that pause.

The address is latched while every select line is high, and the select decoder is enabled only on the following cycle. No select line therefore sees a transient while the address changes.

Top module: `dac_frame_writer`

## Requirements
- R1: After reset, all `sync_n` lines are high, `sclk`, `sdo` and `done` are low, and `req_ready` is high.
- R2: A frame carries 16 bits on `sdo`, one per rising `sclk` edge, as {`req_ctrl`, `req_data`}, most significant bit first.
- R3: `sdo` changes only while `sclk` is low, so it is stable through every high phase.
- R4: The half period is HALF_CYC = max(MIN_HIGH_CYC, MIN_LOW_CYC, ceil(MIN_PERIOD_CYC/2)) cycles. Every high phase lasts exactly HALF_CYC cycles, and so does every low phase between two bits of the same burst.
- R5: The first rising `sclk` edge comes exactly SETUP_CYC + HALF_CYC cycles after the select line falls.
- R6: The select line rises exactly HOLD_CYC cycles after the final falling `sclk` edge of the frame.
- R7: Between two frames, the select line stays high for at least SYNC_HIGH_CYC cycles.
- R8: With `req_split` = 1, the low phase before the 9th rising edge lasts GAP_CYC + HALF_CYC cycles. The select line stays low through that gap and rises only after all 16 bits.
- R9: Address value k drives `sync_n[k]` low and leaves the other lines high. At most one line is ever low, and the latched address does not change while a line is low.
- R10: A request is taken only in a cycle where `req_ready` is high. `req_ready` is low for the whole of a frame, and a `req_valid` raised while busy produces no frame.
- R11: `done` is a one-cycle pulse that comes exactly SYNC_HIGH_CYC cycles after the select line rises. `req_ready` is high in that same cycle, and one pulse is given per frame.
- R12: While every select line is high, `sclk` and `sdo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Writer is idle and will take a request |
| req_ctrl | input | BYTE_W | Control byte, sent first |
| req_data | input | BYTE_W | Data byte, sent second |
| req_addr | input | ADDR_W | Coded device address |
| req_split | input | 1 | 1: two byte bursts with a gap; 0: one 16-bit burst |
| sclk | output | 1 | Shared serial clock, idles low |
| sdo | output | 1 | Shared serial data |
| sync_n | output | 2**ADDR_W | Active-low frame-select line per device |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are a request offered while a frame is in flight, and a new request taken in the very cycle that `done` fires.

For the first, the stimulus holds `req_valid` high with a different payload and address during the opening cycles of a frame. The scoreboard then shows that no extra frame appears and that `req_ready` stays low.

For the second, a run of back-to-back requests keeps `req_valid` waiting for `req_ready`, which returns high together with `done`. The monitor then measures the select-high time, the split-byte gap and every clock phase, cycle by cycle, against values it derives from the parameters.

// File: rtl/dac_fw_pkg.sv
package dac_fw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_GAP,
      ST_HOLD,
      ST_REST
   } fw_state_t;

   function automatic int fw_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dac_fw_timer.sv
module dac_fw_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   if (W < 1) begin : g_bad_w
      $error("dac_fw_timer: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/dac_fw_shifter.sv
module dac_fw_shifter #(
   parameter int FRAME_W  = 16,
   parameter int SPLIT_AT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   input  logic               step,
   output logic               msb,
   output logic               last_bit,
   output logic               split_bit
);

   localparam int BC_W = $clog2(FRAME_W + 1);
   localparam logic [BC_W-1:0] LAST_IDX  = BC_W'(FRAME_W - 1);
   localparam logic [BC_W-1:0] SPLIT_IDX = BC_W'(SPLIT_AT - 1);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("dac_fw_shifter: FRAME_W must be at least 2");
   end
   if (SPLIT_AT < 1 || SPLIT_AT >= FRAME_W) begin : g_bad_split
      $error("dac_fw_shifter: SPLIT_AT must lie inside the frame");
   end

   logic [FRAME_W-1:0] shreg;
   logic [BC_W-1:0]    bitcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         bitcnt <= '0;
      end else if (load) begin
         shreg  <= load_word;
         bitcnt <= '0;
      end else if (step) begin
         shreg  <= {shreg[FRAME_W-2:0], 1'b0};
         bitcnt <= bitcnt + 1'b1;
      end
   end

   assign msb       = shreg[FRAME_W-1];
   assign last_bit  = (bitcnt == LAST_IDX);
   assign split_bit = (bitcnt == SPLIT_IDX);

endmodule

// File: rtl/dac_fw_decode.sv
module dac_fw_decode #(
   parameter int ADDR_W = 2
) (
   input  logic                   en,
   input  logic [ADDR_W-1:0]      addr,
   output logic [(1<<ADDR_W)-1:0] sel_n
);

   localparam int NUM_SEL = 1 << ADDR_W;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("dac_fw_decode: ADDR_W must be at least 1");
   end

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
      assign sel_n[i] = ~(en && (addr == ADDR_W'(i)));
   end

endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
   import dac_fw_pkg::*;
#(
   parameter int ADDR_W         = 2,
   parameter int BYTE_W         = 8,
   parameter int MIN_HIGH_CYC   = 2,
   parameter int MIN_LOW_CYC    = 2,
   parameter int MIN_PERIOD_CYC = 4,
   parameter int SETUP_CYC      = 1,
   parameter int HOLD_CYC       = 1,
   parameter int GAP_CYC        = 4,
   parameter int SYNC_HIGH_CYC  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [BYTE_W-1:0]      req_ctrl,
   input  logic [BYTE_W-1:0]      req_data,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic                   req_split,
   output logic                   sclk,
   output logic                   sdo,
   output logic [(1<<ADDR_W)-1:0] sync_n,
   output logic                   done
);

   localparam int FRAME_W  = 2 * BYTE_W;
   localparam int NUM_DEV  = 1 << ADDR_W;
   localparam int HALF_CYC = fw_max(fw_max(MIN_HIGH_CYC, MIN_LOW_CYC),
                                    (MIN_PERIOD_CYC + 1) / 2);
   localparam int LIM_MAX  = fw_max(fw_max(fw_max(HALF_CYC, SETUP_CYC),
                                           fw_max(HOLD_CYC, GAP_CYC)),
                                    SYNC_HIGH_CYC);
   localparam int CNT_W    = $clog2(LIM_MAX + 1);

   localparam logic [CNT_W-1:0] SETUP_V = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_V  = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_V   = CNT_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] REST_V  = CNT_W'(SYNC_HIGH_CYC - 1);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("dac_frame_writer: BYTE_W must be at least 1");
   end
   if (MIN_HIGH_CYC < 1 || MIN_LOW_CYC < 1 || MIN_PERIOD_CYC < 2) begin : g_bad_clk
      $error("dac_frame_writer: serial clock limits too small");
   end
   if (SETUP_CYC < 1 || HOLD_CYC < 1) begin : g_bad_sync
      $error("dac_frame_writer: select setup and hold must be at least 1");
   end
   if (GAP_CYC < 1 || SYNC_HIGH_CYC < 1) begin : g_bad_gap
      $error("dac_frame_writer: gap and select-high time must be at least 1");
   end

   fw_state_t          state, nxt;
   logic               en_q, sclk_q, done_q, split_q;
   logic [ADDR_W-1:0]  addr_q;
   logic               tmr_load, tmr_zero;
   logic [CNT_W-1:0]   tmr_val;
   logic               frame_load, bit_step;
   logic               sh_msb, sh_last, sh_split;

   dac_fw_timer #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   dac_fw_shifter #(.FRAME_W(FRAME_W), .SPLIT_AT(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_load),
      .load_word ({req_ctrl, req_data}),
      .step      (bit_step),
      .msb       (sh_msb),
      .last_bit  (sh_last),
      .split_bit (sh_split)
   );

   dac_fw_decode #(.ADDR_W(ADDR_W)) u_dec (
      .en    (en_q),
      .addr  (addr_q),
      .sel_n (sync_n)
   );

   always_comb begin
      nxt        = state;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      frame_load = 1'b0;
      bit_step   = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) begin
               nxt        = ST_ARM;
               frame_load = 1'b1;
            end
         end
         ST_ARM: begin
            nxt      = ST_SETUP;
            tmr_load = 1'b1;
            tmr_val  = SETUP_V;
         end
         ST_SETUP: begin
            if (tmr_zero) begin
               nxt      = ST_LOW;
               tmr_load = 1'b1;
               tmr_val  = HALF_V;
            end
         end
         ST_LOW: begin
            if (tmr_zero) begin
               nxt      = ST_HIGH;
               tmr_load = 1'b1;
               tmr_val  = HALF_V;
            end
         end
         ST_HIGH: begin
            if (tmr_zero) begin
               bit_step = 1'b1;
               tmr_load = 1'b1;
               if (sh_last) begin
                  nxt     = ST_HOLD;
                  tmr_val = HOLD_V;
               end else if (split_q && sh_split) begin
                  nxt     = ST_GAP;
                  tmr_val = GAP_V;
               end else begin
                  nxt     = ST_LOW;
                  tmr_val = HALF_V;
               end
            end
         end
         ST_GAP: begin
            if (tmr_zero) begin
               nxt      = ST_LOW;
               tmr_load = 1'b1;
               tmr_val  = HALF_V;
            end
         end
         ST_HOLD: begin
            if (tmr_zero) begin
               nxt      = ST_REST;
               tmr_load = 1'b1;
               tmr_val  = REST_V;
            end
         end
         ST_REST: begin
            if (tmr_zero) begin
               nxt = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         en_q    <= 1'b0;
         sclk_q  <= 1'b0;
         done_q  <= 1'b0;
         split_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         state  <= nxt;
         en_q   <= (nxt != ST_IDLE) && (nxt != ST_ARM) && (nxt != ST_REST);
         sclk_q <= (nxt == ST_HIGH);
         done_q <= (state == ST_REST) && (nxt == ST_IDLE);
         if (frame_load) begin
            addr_q  <= req_addr;
            split_q <= req_split;
         end
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign sclk      = sclk_q;
   assign sdo       = en_q & sh_msb;
   assign done      = done_q;

endmodule

// File: rtl/dac_fw_checker.sv
module dac_fw_checker #(
   parameter int HALF_CYC = 2,
   parameter int ADDR_W   = 2,
   parameter int NUM_DEV  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sclk,
   input logic               sdo,
   input logic [NUM_DEV-1:0] sync_n,
   input logic               done,
   input logic               req_ready,
   input logic [ADDR_W-1:0]  addr_q
);

   logic [15:0] hi_run;
   logic        idle_line;

   assign idle_line = &sync_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
      end else if (sclk) begin
         hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1;
      end else begin
         hi_run <= '0;
      end
   end

   assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sync_n));

   assert_addr_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_line |-> $stable(addr_q));

   assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      idle_line |-> (!sclk && !sdo));

   assert_sdo_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdo));

   assert_high_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_run == 16'(HALF_CYC)));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (idle_line && req_ready));

   assert_busy_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_line |-> !req_ready);

endmodule

bind dac_frame_writer dac_fw_checker #(
   .HALF_CYC (HALF_CYC),
   .ADDR_W   (ADDR_W),
   .NUM_DEV  (NUM_DEV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sclk      (sclk),
   .sdo       (sdo),
   .sync_n    (sync_n),
   .done      (done),
   .req_ready (req_ready),
   .addr_q    (addr_q)
);

// File: tb/sim_dac_frame_writer.sv
module sim_dac_frame_writer;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 2;
   localparam int BYTE_W     = 8;
   localparam int MIN_HIGH   = 2;
   localparam int MIN_LOW    = 3;
   localparam int MIN_PERIOD = 5;
   localparam int SETUP      = 2;
   localparam int HOLD       = 2;
   localparam int GAP        = 5;
   localparam int SYNC_HIGH  = 4;
   localparam int HP_A       = (MIN_HIGH > MIN_LOW) ? MIN_HIGH : MIN_LOW;
   localparam int HP_B       = (MIN_PERIOD + 1) / 2;
   localparam int HALF       = (HP_A > HP_B) ? HP_A : HP_B;
   localparam int WATCHDOG   = 60000;

   typedef struct {
      logic [1:0]  addr;
      logic [15:0] word;
      logic        split;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_ctrl = '0;
   logic [7:0] req_data = '0;
   logic [1:0] req_addr = '0;
   logic       req_split = 1'b0;
   logic       sclk, sdo, done;
   logic [3:0] sync_n;

   int   n_chk = 0;
   int   n_fail = 0;
   int   frames_sent = 0;
   int   frames_seen = 0;
   int   n_done = 0;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_frame_writer #(
      .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .MIN_HIGH_CYC(MIN_HIGH),
      .MIN_LOW_CYC(MIN_LOW), .MIN_PERIOD_CYC(MIN_PERIOD), .SETUP_CYC(SETUP),
      .HOLD_CYC(HOLD), .GAP_CYC(GAP), .SYNC_HIGH_CYC(SYNC_HIGH)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ctrl(req_ctrl), .req_data(req_data), .req_addr(req_addr),
      .req_split(req_split), .sclk(sclk), .sdo(sdo), .sync_n(sync_n), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // driver: waits for idle, offers one request, records the expected frame
   task automatic send(input logic [1:0] a, input logic [7:0] c,
                       input logic [7:0] d, input logic sp);
      exp_t e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_ctrl  = c;
      req_data  = d;
      req_split = sp;
      e.addr  = a;
      e.word  = {c, d};
      e.split = sp;
      exp_q.push_back(e);
      frames_sent++;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: rebuilds frames from the serial pins and scores them
   int   c_fs, c_lo, c_hi, c_fall, c_rise;
   int   nbits;
   logic [15:0] word;
   logic p_sclk, p_act, p_done, quiet_bad, unsteady, seen_frame, have_exp;
   exp_t cur;

   always @(negedge clk) begin
      logic act;
      int   idx;
      if (!rst_n) begin
         c_fs = 0; c_lo = 0; c_hi = 0; c_fall = 0; c_rise = 1000;
         nbits = 0; word = '0; p_sclk = 0; p_act = 0; p_done = 0;
         quiet_bad = 0; unsteady = 0; seen_frame = 0; have_exp = 0;
      end else begin
         c_fs++; c_lo++; c_hi++; c_fall++; c_rise++;
         act = ~&sync_n;
         if (!act && (sclk || sdo)) quiet_bad = 1;
         if (act && !p_act) begin
            chk($countones(~sync_n) == 1, "R9", "one select low", 32'(~sync_n), 1);
            chk(!quiet_bad, "R12", "clock and data low while idle", quiet_bad, 0);
            quiet_bad = 0;
            if (seen_frame) chk(c_rise >= SYNC_HIGH, "R7", "select high time", c_rise, SYNC_HIGH);
            idx = 0;
            for (int i = 0; i < 4; i++) if (!sync_n[i]) idx = i;
            if (exp_q.size() == 0) begin
               have_exp = 0;
               chk(0, "R10", "frame with no request", idx, 0);
            end else begin
               have_exp = 1;
               cur = exp_q[0];
               chk(idx == int'(cur.addr), "R9", "selected line", idx, cur.addr);
            end
            c_fs = 0; nbits = 0; word = '0;
         end
         if (sclk && !p_sclk) begin
            if (nbits == 0)
               chk(c_fs == SETUP + HALF, "R5", "select to first rise", c_fs, SETUP + HALF);
            else if (have_exp && cur.split && nbits == BYTE_W)
               chk(c_lo == GAP + HALF, "R8", "byte gap low time", c_lo, GAP + HALF);
            else
               chk(c_lo == HALF, "R4", "low phase", c_lo, HALF);
            word = {word[14:0], sdo};
            nbits++;
            c_hi = 0;
            unsteady = 0;
         end else if (sclk && sdo != word[0]) begin
            unsteady = 1;
         end
         if (!sclk && p_sclk) begin
            chk(c_hi == HALF, "R4", "high phase", c_hi, HALF);
            chk(!unsteady, "R3", "data steady while clock high", unsteady, 0);
            c_lo = 0;
            c_fall = 0;
         end
         if (!act && p_act) begin
            chk(nbits == 16, "R8", "bits before select rise", nbits, 16);
            chk(c_fall == HOLD, "R6", "last fall to select rise", c_fall, HOLD);
            if (have_exp) begin
               chk(word == cur.word, "R2", "frame content", word, cur.word);
               void'(exp_q.pop_front());
            end
            frames_seen++;
            seen_frame = 1;
            c_rise = 0;
         end
         if (done) begin
            n_done++;
            chk(c_rise == SYNC_HIGH, "R11", "select rise to done", c_rise, SYNC_HIGH);
            chk(!p_done && req_ready, "R11", "single pulse with ready", {p_done, req_ready}, 1);
         end
         p_sclk = sclk;
         p_act  = act;
         p_done = done;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", WATCHDOG, WATCHDOG);
      report();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(&sync_n, "R1", "selects high", sync_n, 4'hF);
      chk(!sclk && !sdo, "R1", "clock and data low", {sclk, sdo}, 0);
      chk(!done, "R1", "done low", done, 0);
      chk(req_ready, "R1", "ready high", req_ready, 1);

      // R2 R4 R5 R6: single bursts and split bursts, assorted patterns
      send(2'd0, 8'hA5, 8'h3C, 1'b0);
      send(2'd3, 8'hFF, 8'h00, 1'b1);
      send(2'd1, 8'h00, 8'hFF, 1'b1);
      send(2'd2, 8'h81, 8'h7E, 1'b0);

      // R10: request held while busy must be dropped
      send(2'd1, 8'h12, 8'h34, 1'b0);
      for (int k = 0; k < 10; k++) begin
         req_valid = 1'b1;
         req_addr  = 2'd2;
         req_ctrl  = 8'hEE;
         req_data  = 8'hEE;
         req_split = 1'b1;
         chk(!req_ready, "R10", "ready low during frame", req_ready, 0);
         @(negedge clk);
      end
      req_valid = 1'b0;

      // R7 R11: back-to-back requests accepted as done fires
      for (int i = 0; i < 8; i++)
         send(2'(i % 4), 8'(i * 37 + 1), ~8'(i * 53), i[0]);

      while (exp_q.size() != 0) @(negedge clk);
      repeat (SYNC_HIGH + 6) @(negedge clk);
      chk(frames_seen == frames_sent, "R10", "frame count", frames_seen, frames_sent);
      chk(n_done == frames_sent, "R11", "done count", n_done, frames_sent);
      chk(&sync_n && !sclk && !sdo, "R12", "line quiet at end", {sync_n, sclk, sdo}, 8'h3C);
      report();
   end

endmodule